// File: doc/BRIEF.md
# Quarter-Rate IF Digital Downconverter

This block turns a real intermediate-frequency sample stream from an 8-bit converter into complex baseband samples at a quarter of the input rate. It is meant for an OFDM receive chain. In that chain the converter runs at 8.192 MS/s, and the 1.536 MHz wide signal is centred at 2.048 MHz, which is exactly fs/4. Each accepted input sample arrives with a strobe. A fixed-point Hilbert FIR derives the quadrature component. The in-phase component is the same sample, taken from the centre of the filter's delay line.

Because the carrier sits at fs/4, the shift to zero frequency needs no oscillator and no multiplier. A four-phase rotation that only swaps and negates multiplies the analytic signal by (-j)^n. An 11-tap low-pass FIR then filters the rotated stream and keeps one sample in four. Each result is rounded and saturated to a parameterised width and presented as an I/Q pair with a one-cycle strobe, which gives 2.048 MS/s at the nominal clocking.

All state advances only on accepted samples. Gaps in the input strobe therefore stretch the pipeline in time without changing any arithmetic result.

Top module: `qrate_ddc`

## Requirements
- R1: Synchronous reset (`rst` high at a clock edge) clears out_valid, out_i, out_q, the rotation phase, the decimation count and both delay lines to zero.
- R2: For accepted sample index n, counted from reset, let x[m] be the m-th accepted input, with x[m]=0 for m<0. With M=(HB_TAPS-1)/2, the quadrature value is Q[n] = sum over odd d from 1 to M of c(d)*(x[n-M-d] - x[n-M+d]). The constants are c(1)=326, c(3)=109, c(5)=65, c(7)=47, c(9)=36 and c(11)=30, in units of 2^-9. Taps at even offsets from the centre are zero and are not built.
- R3: The in-phase value is delay-matched to the Hilbert filter: I[n] = x[n-M]*2^9.
- R4: Rotation uses phase p = n mod 4. The rotated pair (RI,RQ) is (I,Q) for p=0, (Q,-I) for p=1, (-I,-Q) for p=2 and (-Q,I) for p=3.
- R5: The k-th output (k from 0) is formed from n=4k+3 as S = sum over j=0..10 of h(j)*R(n-j), with R(m)=0 for m<0. The taps h are -1,-3,-2,6,18,28,18,6,-2,-3,-1, in units of 2^-6. I and Q are filtered separately.
- R6: Each output is floor((S + 2^14) / 2^15), which rounds half up.
- R7: A rounded value outside the signed OUT_W range is clamped to the nearest end of that range, separately for I and Q.
- R8: While in_valid is low, nothing advances. No output strobe appears except for a group of four accepted samples, out_i and out_q do not change between strobes, and out_valid is never high on two consecutive cycles.
- R9: out_valid is high in the cycle that follows the second rising edge after the edge that captured sample 4k+3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample strobe |
| in_sample | input | IN_W | Signed IF sample |
| out_valid | output | 1 | One-cycle strobe per baseband pair |
| out_i | output | OUT_W | Signed in-phase baseband sample |
| out_q | output | OUT_W | Signed quadrature baseband sample |

## Verification
Two things can fall in the same cycle: the decimator emits an output, and a new sample is accepted or withheld while the previous group is still moving through the pipeline. The bench provokes this with continuous streams, with strobes on every other cycle and with pseudo-random gaps. It also inserts idle windows that leave a partial group of four pending. A sample-indexed arithmetic model judges every strobe for value and latency, and each idle window is checked for a stray strobe or an output that changes.

// File: rtl/qddc_pkg.sv
package qddc_pkg;
   localparam int HB_FRAC     = 9;
   localparam int HB_MAX_TAPS = 23;
   localparam int DEC_TAPS    = 11;
   localparam int DEC_FRAC    = 6;
   localparam int DEC_COEF_W  = 6;
   localparam int DECIM       = 4;

   // Hilbert constants at odd offset d from the centre, scaled by 2^HB_FRAC
   function automatic int hb_coef(input int d);
      case (d)
         1:       return 326;
         3:       return 109;
         5:       return 65;
         7:       return 47;
         9:       return 36;
         11:      return 30;
         default: return 0;
      endcase
   endfunction

   // Anti-alias low-pass taps, scaled by 2^DEC_FRAC (sum 64)
   function automatic int dec_coef(input int j);
      case (j)
         0, 10:   return -1;
         1, 9:    return -3;
         2, 8:    return -2;
         3, 7:    return 6;
         4, 6:    return 18;
         5:       return 28;
         default: return 0;
      endcase
   endfunction
endpackage

// File: rtl/qddc_hilbert.sv
module qddc_hilbert
   import qddc_pkg::*;
#(
   parameter int IN_W = 8,
   parameter int TAPS = 7,
   parameter int HW   = 20
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   shift_en,
   input  logic signed [IN_W-1:0] din,
   output logic signed [HW-1:0]   i_out,
   output logic signed [HW-1:0]   q_out
);
   localparam int MID  = (TAPS - 1) / 2;
   localparam int NODD = (MID + 1) / 2;

   if ((TAPS % 2) == 0 || TAPS < 3 || TAPS > HB_MAX_TAPS) begin : g_bad_taps
      $error("qddc_hilbert: TAPS must be odd and within 3..%0d", HB_MAX_TAPS);
   end

   logic signed [IN_W-1:0] dl [TAPS];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int k = 0; k < TAPS; k++) dl[k] <= '0;
      end else if (shift_en) begin
         dl[0] <= din;
         for (int k = 1; k < TAPS; k++) dl[k] <= dl[k-1];
      end
   end

   logic signed [HW-1:0] pp [NODD];

   for (genvar g = 0; g < NODD; g++) begin : g_tap
      localparam int D = 2*g + 1;
      localparam logic signed [HW-1:0] C = HW'(hb_coef(D));
      logic signed [HW-1:0] older, newer;
      assign older = HW'(dl[MID+D]);
      assign newer = HW'(dl[MID-D]);
      assign pp[g] = (older - newer) * C;
   end

   logic signed [HW-1:0] q_sum;
   always_comb begin
      q_sum = '0;
      for (int g = 0; g < NODD; g++) q_sum = q_sum + pp[g];
   end

   logic signed [HW-1:0] centre;
   assign centre = HW'(dl[MID]);
   assign i_out  = centre <<< HB_FRAC;
   assign q_out  = q_sum;

   a_r8_line_holds: assert property (@(posedge clk) disable iff (rst)
      !shift_en |=> ($stable(dl[0]) && $stable(dl[TAPS-1])));
endmodule

// File: rtl/qddc_rotator.sv
module qddc_rotator #(
   parameter int HW = 20
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 step,
   input  logic signed [HW-1:0] i_in,
   input  logic signed [HW-1:0] q_in,
   output logic signed [HW-1:0] i_out,
   output logic signed [HW-1:0] q_out
);
   logic [1:0] phase;

   always_ff @(posedge clk) begin
      if (rst)       phase <= 2'd0;
      else if (step) phase <= phase + 2'd1;
   end

   always_comb begin
      unique case (phase)
         2'd0: begin i_out = i_in;  q_out = q_in;  end
         2'd1: begin i_out = q_in;  q_out = -i_in; end
         2'd2: begin i_out = -i_in; q_out = -q_in; end
         2'd3: begin i_out = -q_in; q_out = i_in;  end
      endcase
   end

   a_r4_phase_hold: assert property (@(posedge clk) disable iff (rst)
      !step |=> $stable(phase));
endmodule

// File: rtl/qddc_decim.sv
module qddc_decim
   import qddc_pkg::*;
#(
   parameter int HW    = 20,
   parameter int OUT_W = 12
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    en,
   input  logic signed [HW-1:0]    din_i,
   input  logic signed [HW-1:0]    din_q,
   output logic                    out_valid,
   output logic signed [OUT_W-1:0] out_i,
   output logic signed [OUT_W-1:0] out_q
);
   localparam int SW    = HW + DEC_COEF_W + $clog2(DEC_TAPS) + 1;
   localparam int SH    = HB_FRAC + DEC_FRAC;
   localparam int CNT_W = $clog2(DECIM);
   localparam logic signed [SW-1:0] HALF = SW'(1) <<< (SH - 1);
   localparam logic signed [SW-1:0] MAXV = SW'((2 ** (OUT_W - 1)) - 1);
   localparam logic signed [SW-1:0] MINV = -MAXV - SW'(1);

   if (OUT_W < 2 || OUT_W > SW - SH) begin : g_bad_width
      $error("qddc_decim: OUT_W out of range");
   end

   logic signed [HW-1:0] li [DEC_TAPS];
   logic signed [HW-1:0] lq [DEC_TAPS];
   logic [CNT_W-1:0]     cnt;
   logic                 go;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt <= '0;
         go  <= 1'b0;
         for (int k = 0; k < DEC_TAPS; k++) begin
            li[k] <= '0;
            lq[k] <= '0;
         end
      end else begin
         go <= en && (cnt == CNT_W'(DECIM - 1));
         if (en) begin
            cnt   <= cnt + CNT_W'(1);
            li[0] <= din_i;
            lq[0] <= din_q;
            for (int k = 1; k < DEC_TAPS; k++) begin
               li[k] <= li[k-1];
               lq[k] <= lq[k-1];
            end
         end
      end
   end

   logic signed [SW-1:0] pi [DEC_TAPS];
   logic signed [SW-1:0] pq [DEC_TAPS];

   for (genvar j = 0; j < DEC_TAPS; j++) begin : g_mac
      localparam logic signed [SW-1:0] C = SW'(dec_coef(j));
      assign pi[j] = SW'(li[j]) * C;
      assign pq[j] = SW'(lq[j]) * C;
   end

   logic signed [SW-1:0] si, sq, ri, rq;
   always_comb begin
      si = '0;
      sq = '0;
      for (int j = 0; j < DEC_TAPS; j++) begin
         si = si + pi[j];
         sq = sq + pq[j];
      end
      ri = (si + HALF) >>> SH;
      rq = (sq + HALF) >>> SH;
   end

   function automatic logic signed [OUT_W-1:0] clamp(input logic signed [SW-1:0] v);
      if (v > MAXV)      return MAXV[OUT_W-1:0];
      else if (v < MINV) return MINV[OUT_W-1:0];
      else               return v[OUT_W-1:0];
   endfunction

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         out_i     <= '0;
         out_q     <= '0;
      end else begin
         out_valid <= go;
         if (go) begin
            out_i <= clamp(ri);
            out_q <= clamp(rq);
         end
      end
   end

   a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
      out_valid |=> !out_valid);
   a_r8_outputs_hold: assert property (@(posedge clk) disable iff (rst)
      !$past(go) |-> ($stable(out_i) && $stable(out_q)));
   a_r5_emit_needs_sample: assert property (@(posedge clk) disable iff (rst)
      go |-> $past(en));
endmodule

// File: rtl/qrate_ddc.sv
module qrate_ddc
   import qddc_pkg::*;
#(
   parameter int IN_W    = 8,
   parameter int HB_TAPS = 7,
   parameter int OUT_W   = 12
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    in_valid,
   input  logic signed [IN_W-1:0]  in_sample,
   output logic                    out_valid,
   output logic signed [OUT_W-1:0] out_i,
   output logic signed [OUT_W-1:0] out_q
);
   localparam int HW = IN_W + HB_FRAC + 3;

   if (IN_W < 2 || IN_W > 16) begin : g_bad_in
      $error("qrate_ddc: IN_W out of range");
   end

   logic smp_v;
   always_ff @(posedge clk) begin
      if (rst) smp_v <= 1'b0;
      else     smp_v <= in_valid;
   end

   logic signed [HW-1:0] hb_i, hb_q, rot_i, rot_q;

   qddc_hilbert #(.IN_W(IN_W), .TAPS(HB_TAPS), .HW(HW)) hilbert_i (
      .clk(clk), .rst(rst), .shift_en(in_valid), .din(in_sample),
      .i_out(hb_i), .q_out(hb_q));

   qddc_rotator #(.HW(HW)) rotator_i (
      .clk(clk), .rst(rst), .step(smp_v),
      .i_in(hb_i), .q_in(hb_q), .i_out(rot_i), .q_out(rot_q));

   qddc_decim #(.HW(HW), .OUT_W(OUT_W)) decim_i (
      .clk(clk), .rst(rst), .en(smp_v), .din_i(rot_i), .din_q(rot_q),
      .out_valid(out_valid), .out_i(out_i), .out_q(out_q));

   a_r9_latency: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> $past(smp_v, 2));
endmodule

// File: tb/qrate_ddc_tb_top.sv
module qrate_ddc_tb_top;
   localparam int OW   = 6;
   localparam int MAXS = 2048;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic in_valid = 1'b0;
   logic signed [7:0] in_sample = '0;
   logic out_valid;
   logic signed [OW-1:0] out_i, out_q;

   always #4 clk = ~clk;

   qrate_ddc #(.IN_W(8), .HB_TAPS(7), .OUT_W(OW)) dut_i (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
      .out_valid(out_valid), .out_i(out_i), .out_q(out_q));

   int vectors = 0;
   int errors  = 0;
   int cyc     = 0;
   int nx      = 0;
   int nout    = 0;
   int nsat    = 0;
   int xs  [MAXS];
   int cap [MAXS];
   logic [31:0] lfsr = 32'h1234_5678;

   always @(posedge clk) cyc = cyc + 1;

   task automatic check(input string tag, input longint act, input longint exp);
      vectors++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic longint xv(input int m);
      return (m < 0) ? 0 : longint'(xs[m]);
   endfunction

   function automatic longint hcoef(input int d);
      case (d)
         1: return 326;
         3: return 109;
         default: return 0;
      endcase
   endfunction

   function automatic longint dcoef(input int j);
      longint t [11] = '{-1, -3, -2, 6, 18, 28, 18, 6, -2, -3, -1};
      return t[j];
   endfunction

   // Rotated sample n (R2, R3, R4), M = 3 for seven taps
   task automatic rot(input int n, output longint ri, output longint rq);
      longint i, q;
      if (n < 0) begin ri = 0; rq = 0; return; end
      i = xv(n - 3) * 512;
      q = 0;
      for (int d = 1; d <= 3; d += 2) q += hcoef(d) * (xv(n - 3 - d) - xv(n - 3 + d));
      case (n % 4)
         0: begin ri = i;  rq = q;  end
         1: begin ri = q;  rq = -i; end
         2: begin ri = -i; rq = -q; end
         default: begin ri = -q; rq = i; end
      endcase
   endtask

   function automatic longint sat(input longint v);
      longint hi = (64'sd1 <<< (OW - 1)) - 1;
      if (v > hi) return hi;
      if (v < -hi - 1) return -hi - 1;
      return v;
   endfunction

   // Output monitor: R5, R6, R7, R9
   always @(negedge clk) begin
      if (!rst && out_valid) begin
         int n;
         longint si, sq, ri, rq, ui, uq;
         n = 4 * nout + 3;
         si = 0; sq = 0;
         for (int j = 0; j < 11; j++) begin
            rot(n - j, ri, rq);
            si += dcoef(j) * ri;
            sq += dcoef(j) * rq;
         end
         ui = (si + 16384) >>> 15;
         uq = (sq + 16384) >>> 15;
         if (sat(ui) != ui || sat(uq) != uq) nsat++;
         check("R3 R4 R5 R6 R7 out_i", longint'(out_i), sat(ui));
         check("R2 R4 R5 R6 R7 out_q", longint'(out_q), sat(uq));
         check("R9 latency", longint'(cyc), longint'(cap[n] + 2));
         nout++;
      end
   end

   task automatic push(input int x);
      @(negedge clk);
      in_valid  = 1'b1;
      in_sample = 8'(x);
      xs[nx]    = x;
      cap[nx]   = cyc + 1;
      nx++;
   endtask

   task automatic gap(input int n);
      repeat (n) begin
         @(negedge clk);
         in_valid  = 1'b0;
         in_sample = 8'h5A;
      end
   endtask

   // R8: after draining, no strobe and no output change while idle
   task automatic quiet(input int n);
      logic signed [OW-1:0] si, sq;
      int bad;
      gap(4);
      si = out_i; sq = out_q; bad = 0;
      repeat (n) begin
         @(negedge clk);
         if (out_valid || out_i != si || out_q != sq) bad++;
      end
      check("R8 idle hold", longint'(bad), 0);
   endtask

   function automatic int rnd8();
      lfsr = lfsr ^ (lfsr << 13);
      lfsr = lfsr ^ (lfsr >> 17);
      lfsr = lfsr ^ (lfsr << 5);
      return int'($signed(lfsr[7:0]));
   endfunction

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      vectors++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      check("R1 out_valid in reset", longint'(out_valid), 0);
      rst = 1'b0;
      @(negedge clk);
      check("R1 out_valid", longint'(out_valid), 0);
      check("R1 out_i", longint'(out_i), 0);
      check("R1 out_q", longint'(out_q), 0);

      // Impulses: exposes Hilbert taps and delay matching (R2, R3)
      push(127);
      for (int k = 0; k < 15; k++) push(0);
      push(-128);
      for (int k = 0; k < 15; k++) push(0);
      quiet(8);

      // Full sweep of every input code, continuous strobe
      for (int v = -128; v < 128; v++) push(v);
      quiet(6);

      // Full-scale tone at fs/4 lands at zero frequency and saturates (R7)
      for (int k = 0; k < 64; k++) push((k % 4 == 0) ? 127 : (k % 4 == 2) ? -127 : 0);
      // Partial group left pending across an idle window (R8)
      push(100); push(-50);
      quiet(10);

      // Strobe on every other cycle
      for (int k = 0; k < 128; k++) begin
         push(rnd8());
         gap(1);
      end

      // Random gaps, random data
      for (int k = 0; k < 400; k++) begin
         push(rnd8());
         if (lfsr[9]) gap(int'(lfsr[12:11]) + 1);
      end
      gap(8);
      quiet(8);

      check("R7 saturation reached", longint'(nsat > 0), 1);
      check("R8 output count", longint'(nout), longint'(nx / 4));
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule